// File: doc/BRIEF.md
# MDIO Management Slave with Paged Registers

This block is the management end of a PHY-style device. It listens to a two-wire serial management bus using the Clause 22 frame format. The management clock is its only clock, and the bus data line is sampled on each rising edge. A frame is accepted after just one preamble bit. The block decodes the start pattern, the operation, the 5-bit station address and the 5-bit register address. It then either shifts 16 bits of register data out through a driver enable or collects 16 bits of write data.

Behind the frame logic sits a small register file split into two pages. The page is chosen by bit 0 of the shared page register at address 19. Addresses 16, 17 and 19 reach the same storage from either page. The register file holds:

- a control word on each page at address 0;
- read-only identifier words and a live status word on page 0;
- a vendor word;
- a byte of sticky event flags that clears when it is read.

The writable words are also driven out as ports, so the rest of the device can use them.

Top module: `mdio_paged_slave`

## Requirements
- R1: One bit of value 1 ahead of the start pattern is enough preamble. Between frames the line may idle at 0, and a frame still decodes.
- R2: A frame consists of a start pattern of 0 then 1, an opcode, a station address and a register address. The opcode is 1,0 for a read and 0,1 for a write. Both addresses are 5 bits, sent MSB first. Write data follows two turnaround bits and is 16 bits, sent MSB first.
- R3: The block answers when the station address equals `phy_addr` or is 00000. For any other address the driver enable stays low, so a read sees all ones through the pull-up, and a write changes nothing.
- R4: For an answered read, the enable is low during the first turnaround bit. The block then drives 0 in the second turnaround bit and sends the 16 data bits MSB first. The enable falls after the last data bit.
- R5: A write takes effect only at the rising edge that samples the sixteenth data bit. After fifteen data bits the target register still holds its old value.
- R6: The block returns to preamble search without touching any register in two cases. One is a start pattern other than 0,1. The other is an opcode of 0,0 or 1,1.
- R7: Bit 0 of register 19 selects the page, and page 0 is selected after reset. Registers 16, 17 and 19 reach the same storage on both pages. Address 0 on page 1 is a separate control word, output as `alt_q`.
- R8: Reset values are as follows. Page 0 address 0 is 0x0000. Address 2 is 0x000E and address 3 is 0x7121. Address 16 is 0x0000 and address 19 is 0x0000. Page 1 address 0 is 0x0004.
- R9: Certain addresses read as 0x0000 and ignore writes. On page 0 these are 4 to 15, 18 and 20 to 31. On page 1 they are 1 to 15, 18 and 20 to 31. Writes to addresses 1, 2 and 3 on page 0 are also ignored.
- R10: Page 0 address 1 returns the current value of `stat_in`.
- R11: Address 17 returns the event byte in bits 7:0, with bits 15:8 always 0. Each `ev_in` bit that is high at a rising edge sets its flag. A read clears the flags after their value has been loaded for shifting out. An event present at that same edge stays set, and writes to address 17 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled level of the bus data line |
| mdio_o | output | 1 | Data driven onto the bus line |
| mdio_oe | output | 1 | Driver enable for `mdio_o` |
| phy_addr | input | 5 | Station address strap |
| stat_in | input | 16 | Live status word for page 0 address 1 |
| ev_in | input | 8 | Event inputs that set the sticky flags |
| ctrl_q | output | 16 | Page 0 control word |
| alt_q | output | 16 | Page 1 control word |
| vend_q | output | 16 | Shared vendor word |
| page_q | output | 1 | Current page select |

## Verification
The assertions assume the following:

- The bus master never drives the line while `mdio_oe` is high.
- `stat_in` and `ev_in` change only between clock edges.
- Reset is released before the first frame begins.

The bench meets these assumptions in three ways. It drives all of its inputs on falling clock edges. It releases its own driver for the whole turnaround and data phase of every read. It models the line as the slave's value when the enable is high, the master's value when the master drives, and a pull-up otherwise. Every frame is preceded by exactly one 1 after a line idling at 0, so no assertion ever sees a longer preamble than the minimum.

// File: rtl/mdio_paged_slave.sv
module mdio_paged_slave #(
  parameter logic [15:0] ID_HI     = 16'h000E,
  parameter logic [15:0] ID_LO     = 16'h7121,
  parameter logic [15:0] CTRL_INIT = 16'h0000,
  parameter logic [15:0] ALT_INIT  = 16'h0004,
  parameter int          EVW       = 8
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic           mdio_i,
  output logic           mdio_o,
  output logic           mdio_oe,
  input  logic [4:0]     phy_addr,
  input  logic [15:0]    stat_in,
  input  logic [EVW-1:0] ev_in,
  output logic [15:0]    ctrl_q,
  output logic [15:0]    alt_q,
  output logic [15:0]    vend_q,
  output logic           page_q
);
  typedef enum logic [2:0] {S_IDLE, S_ST, S_OP, S_ADR, S_TA, S_DAT} st_t;

  st_t            st;
  logic [3:0]     cnt;
  logic [15:0]    sh;
  logic           pre, rd, hit;
  logic [4:0]     rad;
  logic [15:0]    pgr;
  logic [EVW-1:0] evt;
  logic [15:0]    rdata;

  assign page_q = pgr[0];

  wire        rd_load = (st == S_TA) && (cnt == 4'd1) && rd && hit;
  wire        wr_fire = (st == S_DAT) && (cnt == 4'd15) && !rd && hit;
  wire [15:0] wdata   = {sh[14:0], mdio_i};
  wire [9:0]  adr_w   = {sh[8:0], mdio_i};

  always_comb begin
    rdata = '0;
    case (rad)
      5'd0:    rdata = page_q ? alt_q : ctrl_q;
      5'd1:    if (!page_q) rdata = stat_in;
      5'd2:    if (!page_q) rdata = ID_HI;
      5'd3:    if (!page_q) rdata = ID_LO;
      5'd16:   rdata = vend_q;
      5'd17:   rdata = 16'(evt);
      5'd19:   rdata = pgr;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; pre <= 1'b0; rd <= 1'b0;
      hit <= 1'b0; rad <= '0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (mdio_i) pre <= 1'b1;
          else if (pre) begin
            pre <= 1'b0;
            st  <= S_ST;
          end
        S_ST: begin
          st  <= mdio_i ? S_OP : S_IDLE;
          cnt <= '0;
        end
        S_OP:
          if (cnt == 4'd0) begin
            sh[0] <= mdio_i;
            cnt   <= 4'd1;
          end else if (sh[0] != mdio_i) begin
            rd  <= sh[0];
            st  <= S_ADR;
            cnt <= '0;
          end else st <= S_IDLE;
        S_ADR: begin
          sh  <= {sh[14:0], mdio_i};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd9) begin
            hit <= (adr_w[9:5] == phy_addr) || (adr_w[9:5] == 5'd0);
            rad <= adr_w[4:0];
            st  <= S_TA;
            cnt <= '0;
          end
        end
        S_TA:
          if (cnt == 4'd0) begin
            cnt <= 4'd1;
            if (rd && hit) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end
          end else begin
            st  <= S_DAT;
            cnt <= '0;
            if (rd_load) begin
              mdio_o <= rdata[15];
              sh     <= {rdata[14:0], 1'b0};
            end
          end
        S_DAT: begin
          cnt <= cnt + 4'd1;
          if (rd) begin
            mdio_o <= sh[15];
            sh     <= {sh[14:0], 1'b0};
          end else sh <= wdata;
          if (cnt == 4'd15) begin
            st      <= S_IDLE;
            mdio_oe <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT; alt_q <= ALT_INIT; vend_q <= '0; pgr <= '0;
    end else if (wr_fire) begin
      case (rad)
        5'd0:    if (page_q) alt_q <= wdata; else ctrl_q <= wdata;
        5'd16:   vend_q <= wdata;
        5'd19:   pgr <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= ((rd_load && rad == 5'd17) ? '0 : evt) | ev_in;
  end

  // R4
  ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R4
  oe_end_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> $past(st) == S_DAT);
  // R3
  no_drive_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> hit);
  // R5
  ctrl_commit_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(wr_fire));
  // R7
  page_commit_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    (page_q != $past(page_q)) |-> $past(wr_fire && rad == 5'd19));
  // R6
  bad_op_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == S_OP && cnt == 4'd1 && sh[0] == mdio_i) |=> st == S_IDLE);
  // R11
  evt_clear_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    (|($past(evt) & ~evt)) |-> $past(rd_load && rad == 5'd17));
endmodule

// File: tb/test_mdio_paged_slave.sv
module test_mdio_paged_slave;
  localparam logic [4:0] MY = 5'h0B;

  logic mdc = 1'b0, rst_n = 1'b0;
  logic mdio_o, mdio_oe, mdio_i;
  logic m_en = 1'b1, m_bit = 1'b0;
  logic [15:0] stat_in = 16'h7A5C;
  logic [7:0]  ev_in = 8'h00;
  logic [15:0] ctrl_q, alt_q, vend_q;
  logic page_q;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl = 16'h0000, m_alt = 16'h0004, m_vend = 16'h0000, m_pgr = 16'h0000;
  logic [7:0]  m_evt = 8'h00;

  always #10 mdc = ~mdc;
  assign mdio_i = mdio_oe ? mdio_o : (m_en ? m_bit : 1'b1);

  mdio_paged_slave i_mdio_paged_slave (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .phy_addr(MY), .stat_in(stat_in), .ev_in(ev_in), .ctrl_q(ctrl_q), .alt_q(alt_q),
    .vend_q(vend_q), .page_q(page_q));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc); m_en = 1'b1; m_bit = b;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output bit ta_ok);
    bit h;
    h = (pa == MY) || (pa == 5'd0);
    send_hdr(2'b10, pa, ra);
    @(negedge mdc); m_en = 1'b0; ta_ok = !mdio_oe;
    @(negedge mdc); ta_ok = ta_ok && (h ? (mdio_oe && !mdio_o) : !mdio_oe);
    d = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc); d = {d[14:0], mdio_i};
    end
    @(negedge mdc); ta_ok = ta_ok && !mdio_oe; m_en = 1'b1; m_bit = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] w);
    send_hdr(2'b01, pa, ra);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    @(negedge mdc); m_bit = 1'b0;
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] ra);
    logic pg;
    pg = m_pgr[0];
    case (ra)
      5'd0:  return pg ? m_alt : m_ctrl;
      5'd1:  return pg ? 16'h0 : stat_in;
      5'd2:  return pg ? 16'h0 : 16'h000E;
      5'd3:  return pg ? 16'h0 : 16'h7121;
      5'd16: return m_vend;
      5'd17: return {8'h00, m_evt};
      5'd19: return m_pgr;
      default: return 16'h0;
    endcase
  endfunction

  function automatic void mdl_wr(input logic [4:0] ra, input logic [15:0] w);
    case (ra)
      5'd0:  if (m_pgr[0]) m_alt = w; else m_ctrl = w;
      5'd16: m_vend = w;
      5'd19: m_pgr = w;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] ra, input string base);
    if (ra == 5'd1 && !m_pgr[0]) return "R10";
    if (ra == 5'd0 || ra == 5'd16 || ra == 5'd17 || ra == 5'd19) return base;
    if (!m_pgr[0] && (ra == 5'd2 || ra == 5'd3)) return base;
    return "R9";
  endfunction

  task automatic sweep(input string base);
    logic [15:0] d; bit ta;
    for (int a = 0; a < 32; a++) begin
      do_read(MY, 5'(a), d, ta);
      chk(d == exp_rd(5'(a)), tag_of(5'(a), base), d, exp_rd(5'(a)));
      chk(ta, "R4 turnaround", 16'(ta), 16'h1);
    end
  endtask

  initial begin
    logic [15:0] d; bit ta;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    // R8 reset state at the ports
    chk(ctrl_q == 16'h0000 && alt_q == 16'h0004 && vend_q == 16'h0 && !page_q && !mdio_oe,
        "R8 reset ports", ctrl_q, 16'h0000);
    // R1 R8 R9 R10: every page 0 address with single-bit preamble frames
    sweep("R8");
    // R2 R9: write every page 0 address, then read back
    for (int a = 0; a < 32; a++) begin
      logic [15:0] w;
      w = 16'hA5A4 ^ (16'(a) * 16'h0111);
      w[0] = 1'b0;
      do_write(MY, 5'(a), w); mdl_wr(5'(a), w);
    end
    sweep("R2");
    chk(ctrl_q == m_ctrl, "R2 ctrl port", ctrl_q, m_ctrl);
    chk(vend_q == m_vend, "R2 vendor port", vend_q, m_vend);
    // R3 station address sweep, reads of shared register 16
    for (int p = 0; p < 32; p++) begin
      logic [15:0] e;
      e = (p == 0 || 5'(p) == MY) ? m_vend : 16'hFFFF;
      do_read(5'(p), 5'd16, d, ta);
      chk(d == e && ta, "R3 address match", d, e);
    end
    do_write(5'h15, 5'd16, 16'h1234);
    do_read(5'd0, 5'd16, d, ta);
    chk(d == m_vend, "R3 foreign write ignored", d, m_vend);
    do_write(5'd0, 5'd16, 16'h5AC3); mdl_wr(5'd16, 16'h5AC3);
    chk(vend_q == 16'h5AC3, "R3 broadcast write", vend_q, 16'h5AC3);
    // R7 switch to page 1 and sweep
    do_write(MY, 5'd19, 16'h0001); mdl_wr(5'd19, 16'h0001);
    chk(page_q == 1'b1, "R7 page port", 16'(page_q), 16'h1);
    sweep("R7");
    for (int a = 0; a < 32; a++) begin
      logic [15:0] w;
      w = 16'h3C01 ^ (16'(a) << 4);
      do_write(MY, 5'(a), w); mdl_wr(5'(a), w);
    end
    sweep("R7");
    chk(alt_q == m_alt && ctrl_q == m_ctrl, "R7 page 1 control isolated", alt_q, m_alt);
    do_write(MY, 5'd19, 16'h0000); mdl_wr(5'd19, 16'h0000);
    do_read(MY, 5'd0, d, ta);
    chk(d == m_ctrl, "R7 page 0 restored", d, m_ctrl);
    // R5 commit only on sixteenth bit
    send_hdr(2'b01, MY, 5'd0);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 1; i--) send_bit(~m_ctrl[i]);
    send_bit(~m_ctrl[0]);
    chk(ctrl_q == m_ctrl, "R5 after fifteen bits", ctrl_q, m_ctrl);
    @(negedge mdc); m_bit = 1'b0;
    chk(ctrl_q == ~m_ctrl, "R5 after sixteenth bit", ctrl_q, ~m_ctrl);
    m_ctrl = ~m_ctrl;
    // R6 bad opcodes and bad start
    send_hdr(2'b11, MY, 5'd16); repeat (4) send_bit(1'b0);
    send_hdr(2'b00, MY, 5'd16); repeat (4) send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); repeat (4) send_bit(1'b0);
    chk(vend_q == m_vend && ctrl_q == m_ctrl && !page_q, "R6 no change", vend_q, m_vend);
    do_read(MY, 5'd16, d, ta);
    chk(d == m_vend && ta, "R6 resync", d, m_vend);
    // R10 live status
    stat_in = 16'h0F1E;
    do_read(MY, 5'd1, d, ta);
    chk(d == 16'h0F1E, "R10 status", d, 16'h0F1E);
    // R11 sticky events, clear on read
    @(negedge mdc); ev_in = 8'h05;
    @(negedge mdc); ev_in = 8'h00;
    do_write(MY, 5'd17, 16'h0000);
    do_read(MY, 5'd17, d, ta);
    chk(d == 16'h0005, "R11 event set", d, 16'h0005);
    do_read(MY, 5'd17, d, ta);
    chk(d == 16'h0000, "R11 cleared by read", d, 16'h0000);
    ev_in = 8'h20;
    do_read(MY, 5'd17, d, ta);
    chk(d == 16'h0020, "R11 held event", d, 16'h0020);
    ev_in = 8'h00;
    do_read(MY, 5'd17, d, ta);
    chk(d == 16'h0020, "R11 set wins over clear", d, 16'h0020);
    do_read(MY, 5'd17, d, ta);
    chk(d == 16'h0000, "R11 second clear", d, 16'h0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule